// File: doc/BRIEF.md
# Mode-Controlled Digital Oscillator with Holdover

This block is a phase-accumulator oscillator clocked by the 20 MHz master oscillator. On every master clock edge it adds a frequency word to its accumulator. The word is a fixed nominal step plus a signed correction. The accumulator's top bit is the synthesized output clock, and the whole accumulator is also available as the output phase.

The operating mode decides which correction is applied. In normal operation the correction comes from the loop filter and is sampled whenever its valid strobe is high. In holdover the block plays back a correction it stored while it was locked. In free-run no correction is applied, so the output is exactly as accurate as the master oscillator.

Two select pins choose the mode. The block also drops into holdover on its own when the reference is reported lost. To make sure the held frequency is always 30 to 60 ms old, the block keeps a two-deep history of the correction, sampled every 30 ms. When it enters holdover it takes the older of the two entries.

Top module: `mode_dco`

## Requirements
- R1: The select pins `mode_sel` decode as follows. `2'b00` means normal, `2'b01` means holdover, and `2'b10` and the spare code `2'b11` both mean free-run. The decoded mode appears on `mode_o` one clock after the pins are sampled, using the codes normal `2'b00`, holdover `2'b01` and free-run `2'b10`.
- R2: While `mode_sel` is `2'b00` and `ref_lost` is high, `mode_o` shows holdover on the next clock. When `ref_lost` falls while `mode_sel` is still `2'b00`, `mode_o` shows normal on the next clock with no other action needed.
- R3: In normal mode, a `corr_in` value sampled with `corr_valid` high is applied from the following clock onward. Each clock then advances `phase_o` by `NOMINAL` plus the signed correction, modulo 2^`ACC_W`.
- R4: In free-run mode, `phase_o` advances by exactly `NOMINAL` each clock, whatever `corr_in` and `corr_valid` do.
- R5: Every `SNAP_PERIOD` clocks spent in normal mode, the applied correction is pushed into a two-entry history. On entering holdover the older entry becomes the applied correction, so the held value comes from one to two periods earlier. Both entries are zero after reset.
- R6: While in holdover, `corr_valid` and `corr_in` are ignored.
- R7: On returning from holdover to normal, the held correction stays in use until the next `corr_valid` sample, and the accumulator is not reset.
- R8: `clk_out` equals the most significant bit of `phase_o`.
- R9: After reset, `phase_o` is zero, `clk_out` is low and `mode_o` shows free-run (`2'b10`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Mode select pins: bit 1 = high pin, bit 0 = low pin |
| ref_lost | input | 1 | High when the selected reference is lost |
| corr_in | input | CORR_W | Signed loop-filter correction |
| corr_valid | input | 1 | Strobe qualifying `corr_in` |
| mode_o | output | 2 | Current operating mode |
| phase_o | output | ACC_W | Phase accumulator value |
| clk_out | output | 1 | Synthesized clock (accumulator MSB) |

## Verification
A change on `mode_sel` or `ref_lost` shows on `mode_o` one clock later. A correction sampled with its strobe at one edge first moves the phase step at the edge after that. A holdover entry swaps the correction at the entry edge, and the new step appears from the next edge. For these reasons the bench drives inputs on falling edges and lets two rising edges pass after any change before it starts a measurement. It then reads `phase_o` on falling edges and compares the difference over a fixed number of edges against that many steps of the expected frequency word. For the holdover case the bench counts exactly `SNAP_PERIOD` edges after loading a new correction, which guarantees that exactly one history push falls in that window, so the older entry is known.

// File: rtl/mode_dco.sv
module mode_dco #(
  parameter int ACC_W       = 32,
  parameter int CORR_W      = 16,
  parameter logic [ACC_W-1:0] NOMINAL = 32'h1999_999A,
  parameter int SNAP_PERIOD = 600000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              ref_lost,
  input  logic [CORR_W-1:0] corr_in,
  input  logic              corr_valid,
  output logic [1:0]        mode_o,
  output logic [ACC_W-1:0]  phase_o,
  output logic              clk_out
);
  localparam int CNT_W = $clog2(SNAP_PERIOD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SNAP_PERIOD - 1);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_HOLD = 2'b01;
  localparam logic [1:0] M_FREE = 2'b10;

  logic [1:0]        mode_d, mode_q;
  logic [CORR_W-1:0] corr_q, hist_new, hist_old, corr_use;
  logic [CNT_W-1:0]  snap_cnt;
  logic [ACC_W-1:0]  acc_q, step;
  logic              snap_now, hold_entry;

  always_comb begin
    if (mode_sel[1])
      mode_d = M_FREE;
    else if (mode_sel[0] || ref_lost)
      mode_d = M_HOLD;
    else
      mode_d = M_NORM;
  end

  assign hold_entry = (mode_d == M_HOLD) && (mode_q != M_HOLD);
  assign snap_now   = (snap_cnt == CNT_LAST) && (mode_q == M_NORM);
  assign corr_use   = (mode_q == M_FREE) ? '0 : corr_q;
  assign step       = NOMINAL + {{(ACC_W-CORR_W){corr_use[CORR_W-1]}}, corr_use};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_FREE;
      corr_q   <= '0;
      hist_new <= '0;
      hist_old <= '0;
      snap_cnt <= '0;
      acc_q    <= '0;
    end else begin
      mode_q   <= mode_d;
      acc_q    <= acc_q + step;
      snap_cnt <= (snap_cnt == CNT_LAST) ? '0 : snap_cnt + 1'b1;
      if (snap_now) begin
        hist_old <= hist_new;
        hist_new <= corr_q;
      end
      if (hold_entry)
        corr_q <= hist_old;
      else if (mode_d == M_NORM && corr_valid)
        corr_q <= corr_in;
    end
  end

  assign mode_o  = mode_q;
  assign phase_o = acc_q;
  assign clk_out = acc_q[ACC_W-1];

  // Mode decode and automatic holdover on reference loss
  assert_free_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[1] |=> mode_o == M_FREE);
  assert_hold_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |=> mode_o == M_HOLD);
  assert_auto_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && ref_lost) |=> mode_o == M_HOLD);
  assert_auto_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !ref_lost) |=> mode_o == M_NORM);

  // Live correction sampling in normal mode
  assert_live_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !ref_lost && corr_valid) |=> corr_q == $past(corr_in));

  // Free-run ignores correction entirely
  assert_free_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == M_FREE |=> phase_o == $past(phase_o) + NOMINAL);

  // Holdover takes the older history entry at entry
  assert_hold_older_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_entry |=> corr_q == $past(hist_old));

  // Holdover keeps the correction regardless of strobes
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_HOLD && mode_d == M_HOLD) |=> $stable(corr_q));
endmodule

// File: tb/mode_dco_tb_top.sv
module mode_dco_tb_top;
  localparam int ACC_W = 24;
  localparam int CORR_W = 12;
  localparam logic [ACC_W-1:0] NOM = 24'h010000;
  localparam int SNAP = 20;
  localparam int N = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 2'b00;
  logic ref_lost = 0, corr_valid = 0;
  logic [CORR_W-1:0] corr_in = '0;
  logic [1:0] mode_o;
  logic [ACC_W-1:0] phase_o;
  logic clk_out;
  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  mode_dco #(.ACC_W(ACC_W), .CORR_W(CORR_W), .NOMINAL(NOM), .SNAP_PERIOD(SNAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_lost(ref_lost),
    .corr_in(corr_in), .corr_valid(corr_valid), .mode_o(mode_o),
    .phase_o(phase_o), .clk_out(clk_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [ACC_W-1:0] exp_delta(input int c);
    return ACC_W'(N * (int'(NOM) + c));
  endfunction

  task automatic measure(output logic [ACC_W-1:0] d);
    logic [ACC_W-1:0] p0;
    @(negedge clk); p0 = phase_o;
    repeat (N) @(posedge clk);
    @(negedge clk); d = phase_o - p0;
  endtask

  task automatic settle(); repeat (2) @(posedge clk); endtask

  task automatic load(input int c);
    @(negedge clk); corr_in = CORR_W'(c); corr_valid = 1;
    @(posedge clk);
    @(negedge clk); corr_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 phase", 32'(phase_o), 0);
    chk("R9 clk_out", 32'(clk_out), 0);
    chk("R9 mode", 32'(mode_o), 2);
  endtask

  task automatic t_normal();
    logic [ACC_W-1:0] d;
    @(negedge clk); mode_sel = 2'b00; ref_lost = 0;
    load(100); settle();
    chk("R1 normal mode", 32'(mode_o), 0);
    measure(d); chk("R3 positive corr", 32'(d), 32'(exp_delta(100)));
    load(-50); settle();
    measure(d); chk("R3 negative corr", 32'(d), 32'(exp_delta(-50)));
    @(negedge clk); chk("R8 clk_out", 32'(clk_out), 32'(phase_o[ACC_W-1]));
  endtask

  task automatic t_free(input logic [1:0] sel, input string tag);
    logic [ACC_W-1:0] d;
    @(negedge clk); mode_sel = sel; corr_in = CORR_W'(300); corr_valid = 1;
    settle();
    chk({tag, " mode"}, 32'(mode_o), 2);
    measure(d); chk({"R4 ", tag, " step"}, 32'(d), 32'(exp_delta(0)));
    @(negedge clk); corr_valid = 0;
  endtask

  task automatic t_lost_in_free();
    @(negedge clk); mode_sel = 2'b10; ref_lost = 1;
    settle(); @(negedge clk);
    chk("R1 lost in freerun stays free", 32'(mode_o), 2);
    ref_lost = 0;
  endtask

  task automatic t_holdover();
    logic [ACC_W-1:0] d;
    @(negedge clk); mode_sel = 2'b00; ref_lost = 0;
    load(200);
    repeat (3 * SNAP) @(posedge clk);
    load(300);
    repeat (SNAP - 1) @(posedge clk);
    @(negedge clk); ref_lost = 1; corr_in = CORR_W'(999); corr_valid = 1;
    settle();
    chk("R2 auto holdover", 32'(mode_o), 1);
    measure(d); chk("R5 older entry held", 32'(d), 32'(exp_delta(200)));
    measure(d); chk("R6 valid ignored in hold", 32'(d), 32'(exp_delta(200)));
    @(negedge clk); corr_valid = 0; ref_lost = 0;
    settle();
    chk("R2 auto return", 32'(mode_o), 0);
    measure(d); chk("R7 held until valid", 32'(d), 32'(exp_delta(200)));
    load(50); settle();
    measure(d); chk("R7 live resumes", 32'(d), 32'(exp_delta(50)));
  endtask

  task automatic t_pin_hold();
    logic [ACC_W-1:0] d;
    @(negedge clk); mode_sel = 2'b01; ref_lost = 0;
    settle();
    chk("R1 pin holdover", 32'(mode_o), 1);
    measure(d); chk("R5 reset history zero", 32'(d), 32'(exp_delta(0)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_pin_hold();
    t_normal();
    t_free(2'b10, "R1 freerun");
    t_free(2'b11, "R1 reserved");
    t_lost_in_free();
    t_holdover();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule